// File: doc/BRIEF.md
# PHY Power and Reset Sequencer

This controller decides when the core of a small Ethernet physical-layer device has power, when it is held in reset, and when its transmitter must stay quiet. The management domain, this controller included, stays powered at all times. There are two ways to power the core down. The first is a power-down bit held in a management register. The core stays off while the bit is set and goes through a full reset when the bit is cleared. The second is an automatic sleep, allowed by an enable bit, that turns the core off while no line energy is detected. It wakes the core without a reset once energy returns.

Three sources can reset the core: the external active-low reset pin, a soft-reset request from management, and the exit from general power-down. The pin counts only if it stays low for a minimum time, 100 µs by default, which the controller measures in clock cycles from its clock frequency. The line-energy input is asynchronous and passes through two flops. An energy-driven wake can raise a sticky interrupt, which management clears with a pulse.

The state machine has four states. RESET holds the core powered but in reset. ACTIVE is normal operation. PD_GENERAL is general power-down. PD_ENERGY is energy-detect sleep. Its transitions are: boot (RESET→ACTIVE), pin_reset (any state→RESET), soft_reset (ACTIVE or PD_ENERGY→RESET), pd_enter (ACTIVE or PD_ENERGY→PD_GENERAL), pd_exit (PD_GENERAL→RESET), sleep (ACTIVE→PD_ENERGY), wake (PD_ENERGY→ACTIVE on energy) and sleep_off (PD_ENERGY→ACTIVE when the enable bit clears).

Top module: `phy_pwr_ctrl`

## Requirements
- R1: While `arst_n` is low, and for RST_HOLD (8) cycles after it goes high, the block is in RESET: `core_pwr_en`=1, `core_rst`=1, `tx_inhibit`=1, `irq`=0 and `energy_on`=0. After that it enters ACTIVE: `core_pwr_en`=1, `core_rst`=0, `tx_inhibit`=0.
- R2: When `pd_general` is high in ACTIVE or PD_ENERGY, the block enters PD_GENERAL at the next clock edge: `core_pwr_en`=0, `core_rst`=1, `tx_inhibit`=1. It stays there while the bit is high.
- R3: When `pd_general` goes low in PD_GENERAL, the block enters RESET, stays there for RST_HOLD cycles, and then enters ACTIVE.
- R4: When `edpd_en` is high and `energy_on` is low in ACTIVE, the block enters PD_ENERGY: `core_pwr_en`=0, `core_rst`=0, `tx_inhibit`=1. When `edpd_en` is low, the absence of energy has no effect.
- R5: In PD_ENERGY, a high `energy_on` returns the block to ACTIVE without asserting `core_rst`. Clearing `edpd_en` also returns it to ACTIVE.
- R6: `energy_on` equals `line_energy` delayed by two clock edges.
- R7: `irq` is set on a wake from PD_ENERGY caused by energy if `irq_en` is high, and not otherwise. Once set, it stays high until `irq_clear` is high at a clock edge. If setting and clearing happen at the same edge, setting wins.
- R8: If `rst_pin_n`, after its two-flop synchronizer, is low for at least MIN_RST_CYC consecutive cycles, the block enters RESET. MIN_RST_CYC is CLK_HZ/1e6 × MIN_RST_US, which is 5000 by default. The block stays in RESET while the pin remains qualified low, and for RST_HOLD cycles after that. A shorter pulse has no effect.
- R9: A high `soft_rst` at a clock edge in ACTIVE or PD_ENERGY sends the block to RESET for RST_HOLD cycles. In PD_GENERAL and in RESET, `soft_rst` is ignored.
- R10: When several conditions hold at once, they are served in this order: pin reset, then soft reset, then general power-down, then energy wake, then energy sleep or sleep_off.
- R11: `tx_inhibit` is high whenever the core is unpowered or in reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Management-domain clock |
| arst_n | input | 1 | Asynchronous power-on reset of the controller, active low |
| rst_pin_n | input | 1 | External hardware reset pin, active low, asynchronous |
| soft_rst | input | 1 | Soft-reset request, one-cycle pulse |
| pd_general | input | 1 | General power-down control bit |
| edpd_en | input | 1 | Enables energy-detect sleep |
| line_energy | input | 1 | Raw line-energy indication, asynchronous |
| irq_en | input | 1 | Enables the energy-wake interrupt |
| irq_clear | input | 1 | Clears the sticky interrupt |
| core_pwr_en | output | 1 | Power enable for the core domain |
| core_rst | output | 1 | Reset to the core domain, active high |
| tx_inhibit | output | 1 | Blocks the transmitter |
| energy_on | output | 1 | Synchronized energy status |
| irq | output | 1 | Sticky energy-wake interrupt |

## Verification
The assertions check four rules on every cycle. The transmitter is blocked whenever the core is unpowered or in reset. Every exit from general power-down passes through reset. A wake from energy sleep never raises the core reset. The interrupt stays set until cleared and is set only by an enabled wake. Other behaviour needs the bench's scenarios. These include rejecting a reset-pin pulse one cycle shorter than the minimum and accepting one of exactly the minimum, the two-edge latency of the energy status, the priority between inputs that arrive together, and ignoring a soft reset during general power-down. The bench checks these against a cycle model built from the requirements.

// File: rtl/pdr_pkg.sv
package pdr_pkg;
    typedef enum logic [1:0] {
        ST_RESET      = 2'd0,
        ST_ACTIVE     = 2'd1,
        ST_PD_GENERAL = 2'd2,
        ST_PD_ENERGY  = 2'd3
    } pdr_state_e;
endpackage

// File: rtl/pdr_sync.sv
// Two-flop synchronizer for asynchronous level inputs.
module pdr_sync #(
    parameter int   W       = 1,
    parameter logic RST_VAL = 1'b0
) (
    input  logic         clk,
    input  logic         arst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage1;

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) begin
            stage1 <= {W{RST_VAL}};
            q      <= {W{RST_VAL}};
        end else begin
            stage1 <= d;
            q      <= stage1;
        end
    end
endmodule

// File: rtl/pdr_pin_qual.sv
// Measures how long the synchronized reset pin has been low.
// The output is high once the pin has been low for MIN_CYC consecutive cycles.
module pdr_pin_qual #(
    parameter int MIN_CYC = 5000
) (
    input  logic clk,
    input  logic arst_n,
    input  logic pin_low,
    output logic qualified
);
    localparam int CW = $clog2(MIN_CYC + 1);
    localparam logic [CW-1:0] LIMIT = CW'(MIN_CYC);

    logic [CW-1:0] low_cnt;

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) begin
            low_cnt <= '0;
        end else if (!pin_low) begin
            low_cnt <= '0;
        end else if (low_cnt != LIMIT) begin
            low_cnt <= low_cnt + 1'b1;
        end
    end

    assign qualified = (low_cnt == LIMIT);
endmodule

// File: rtl/pdr_irq.sv
// Sticky interrupt flag; a set wins over a clear at the same edge.
module pdr_irq (
    input  logic clk,
    input  logic arst_n,
    input  logic set,
    input  logic clr,
    output logic flag
);
    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) begin
            flag <= 1'b0;
        end else if (set) begin
            flag <= 1'b1;
        end else if (clr) begin
            flag <= 1'b0;
        end
    end
endmodule

// File: rtl/pdr_fsm.sv
// Power and reset sequencing state machine.
module pdr_fsm
    import pdr_pkg::*;
#(
    parameter int RST_HOLD = 8
) (
    input  logic clk,
    input  logic arst_n,
    input  logic hw_hold,
    input  logic soft_rst,
    input  logic pd_general,
    input  logic edpd_en,
    input  logic energy,
    output logic core_pwr_en,
    output logic core_rst,
    output logic tx_inhibit,
    output logic wake_evt
);
    localparam int CW = $clog2(RST_HOLD + 1);
    localparam logic [CW-1:0] HOLD_LOAD = CW'(RST_HOLD - 1);

    pdr_state_e    state, state_nxt;
    logic [CW-1:0] hold_cnt;

    // Next-state logic. Priority: pin reset, soft reset, power-down, energy.
    always_comb begin
        state_nxt = state;
        wake_evt  = 1'b0;
        unique case (state)
            ST_RESET: begin
                if (!hw_hold && hold_cnt == '0) state_nxt = ST_ACTIVE;  // boot
            end
            ST_ACTIVE: begin
                if (hw_hold)                    state_nxt = ST_RESET;       // pin_reset
                else if (soft_rst)              state_nxt = ST_RESET;       // soft_reset
                else if (pd_general)            state_nxt = ST_PD_GENERAL;  // pd_enter
                else if (edpd_en && !energy)    state_nxt = ST_PD_ENERGY;   // sleep
            end
            ST_PD_GENERAL: begin
                if (hw_hold)                    state_nxt = ST_RESET;       // pin_reset
                else if (!pd_general)           state_nxt = ST_RESET;       // pd_exit
            end
            ST_PD_ENERGY: begin
                if (hw_hold)                    state_nxt = ST_RESET;       // pin_reset
                else if (soft_rst)              state_nxt = ST_RESET;       // soft_reset
                else if (pd_general)            state_nxt = ST_PD_GENERAL;  // pd_enter
                else if (energy) begin
                    state_nxt = ST_ACTIVE;                                  // wake
                    wake_evt  = 1'b1;
                end
                else if (!edpd_en)              state_nxt = ST_ACTIVE;      // sleep_off
            end
            default: state_nxt = ST_RESET;
        endcase
    end

    // State register and reset-hold timer.
    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) begin
            state    <= ST_RESET;
            hold_cnt <= HOLD_LOAD;
        end else begin
            state <= state_nxt;
            if (state_nxt == ST_RESET && (state != ST_RESET || hw_hold)) begin
                hold_cnt <= HOLD_LOAD;
            end else if (state == ST_RESET && hold_cnt != '0) begin
                hold_cnt <= hold_cnt - 1'b1;
            end
        end
    end

    // Moore outputs.
    always_comb begin
        unique case (state)
            ST_RESET:      begin core_pwr_en = 1'b1; core_rst = 1'b1; tx_inhibit = 1'b1; end
            ST_ACTIVE:     begin core_pwr_en = 1'b1; core_rst = 1'b0; tx_inhibit = 1'b0; end
            ST_PD_GENERAL: begin core_pwr_en = 1'b0; core_rst = 1'b1; tx_inhibit = 1'b1; end
            ST_PD_ENERGY:  begin core_pwr_en = 1'b0; core_rst = 1'b0; tx_inhibit = 1'b1; end
            default:       begin core_pwr_en = 1'b1; core_rst = 1'b1; tx_inhibit = 1'b1; end
        endcase
    end
endmodule

// File: rtl/phy_pwr_ctrl.sv
module phy_pwr_ctrl #(
    parameter int CLK_HZ     = 50_000_000,
    parameter int MIN_RST_US = 100,
    parameter int RST_HOLD   = 8
) (
    input  logic clk,
    input  logic arst_n,
    input  logic rst_pin_n,
    input  logic soft_rst,
    input  logic pd_general,
    input  logic edpd_en,
    input  logic line_energy,
    input  logic irq_en,
    input  logic irq_clear,
    output logic core_pwr_en,
    output logic core_rst,
    output logic tx_inhibit,
    output logic energy_on,
    output logic irq
);
    localparam int MIN_RST_CYC = (CLK_HZ / 1_000_000) * MIN_RST_US;

    logic pin_sync;
    logic hw_hold;
    logic wake_evt;

    pdr_sync #(.W(1), .RST_VAL(1'b0)) i_energy_sync (
        .clk(clk), .arst_n(arst_n), .d(line_energy), .q(energy_on)
    );

    pdr_sync #(.W(1), .RST_VAL(1'b1)) i_pin_sync (
        .clk(clk), .arst_n(arst_n), .d(rst_pin_n), .q(pin_sync)
    );

    pdr_pin_qual #(.MIN_CYC(MIN_RST_CYC)) i_pin_qual (
        .clk(clk), .arst_n(arst_n), .pin_low(!pin_sync), .qualified(hw_hold)
    );

    pdr_fsm #(.RST_HOLD(RST_HOLD)) i_fsm (
        .clk(clk), .arst_n(arst_n), .hw_hold(hw_hold), .soft_rst(soft_rst),
        .pd_general(pd_general), .edpd_en(edpd_en), .energy(energy_on),
        .core_pwr_en(core_pwr_en), .core_rst(core_rst), .tx_inhibit(tx_inhibit),
        .wake_evt(wake_evt)
    );

    pdr_irq i_irq (
        .clk(clk), .arst_n(arst_n), .set(wake_evt && irq_en), .clr(irq_clear), .flag(irq)
    );
endmodule

// File: rtl/pdr_checker.sv
module pdr_checker (
    input logic clk,
    input logic arst_n,
    input logic core_pwr_en,
    input logic core_rst,
    input logic tx_inhibit,
    input logic irq,
    input logic irq_en,
    input logic irq_clear,
    input logic soft_rst,
    input logic hw_hold
);
    a_r11_tx_blocked: assert property (@(posedge clk) disable iff (!arst_n)
        (!core_pwr_en || core_rst) |-> tx_inhibit);

    a_r3_pd_exit_resets: assert property (@(posedge clk) disable iff (!arst_n)
        ($past(!core_pwr_en && core_rst) && core_pwr_en) |-> core_rst);

    a_r5_wake_no_reset: assert property (@(posedge clk) disable iff (!arst_n)
        ($past(!core_pwr_en && !core_rst) && core_pwr_en
         && !$past(hw_hold) && !$past(soft_rst)) |-> !core_rst);

    a_r7_irq_sticky: assert property (@(posedge clk) disable iff (!arst_n)
        (irq && !irq_clear) |=> irq);

    a_r7_irq_source: assert property (@(posedge clk) disable iff (!arst_n)
        $rose(irq) |-> ($past(irq_en) && $past(!core_pwr_en) && core_pwr_en));
endmodule

bind phy_pwr_ctrl pdr_checker i_pdr_checker (
    .clk(clk), .arst_n(arst_n), .core_pwr_en(core_pwr_en), .core_rst(core_rst),
    .tx_inhibit(tx_inhibit), .irq(irq), .irq_en(irq_en), .irq_clear(irq_clear),
    .soft_rst(soft_rst), .hw_hold(hw_hold)
);

// File: tb/test_phy_pwr_ctrl.sv
`timescale 1ns/1ps
module test_phy_pwr_ctrl;
    localparam int CLK_HZ = 50_000_000;
    localparam int MIN    = (CLK_HZ / 1_000_000) * 100;
    localparam int HOLD   = 8;

    logic clk = 1'b0;
    logic arst_n = 1'b0;
    logic rst_pin_n = 1'b1, soft_rst = 1'b0, pd_general = 1'b0, edpd_en = 1'b0;
    logic line_energy = 1'b0, irq_en = 1'b0, irq_clear = 1'b0;
    logic core_pwr_en, core_rst, tx_inhibit, energy_on, irq;

    int total = 0;
    int bad   = 0;
    bit rst_seen = 1'b0;

    always #10 clk = ~clk;

    phy_pwr_ctrl #(.CLK_HZ(CLK_HZ), .MIN_RST_US(100), .RST_HOLD(HOLD)) i_phy_pwr_ctrl (
        .clk(clk), .arst_n(arst_n), .rst_pin_n(rst_pin_n), .soft_rst(soft_rst),
        .pd_general(pd_general), .edpd_en(edpd_en), .line_energy(line_energy),
        .irq_en(irq_en), .irq_clear(irq_clear), .core_pwr_en(core_pwr_en),
        .core_rst(core_rst), .tx_inhibit(tx_inhibit), .energy_on(energy_on), .irq(irq)
    );

    // Cycle model from the requirements. States: 0 RESET, 1 ACTIVE, 2 PD_GENERAL, 3 PD_ENERGY.
    int m_st, m_cnt, m_low;
    bit m_e1, m_e2, m_h1, m_h2, m_irq;

    always @(posedge clk or negedge arst_n) begin
        if (!arst_n) begin
            m_st <= 0; m_cnt <= HOLD - 1; m_low <= 0; m_irq <= 0;
            m_e1 <= 0; m_e2 <= 0; m_h1 <= 1; m_h2 <= 1;
        end else begin
            bit hh, wk;
            int nst;
            hh  = (m_low == MIN);
            wk  = 0;
            nst = m_st;
            case (m_st)
                0: if (!hh && m_cnt == 0) nst = 1;
                1: if (hh || soft_rst) nst = 0;
                   else if (pd_general) nst = 2;
                   else if (edpd_en && !m_e2) nst = 3;
                2: if (hh || !pd_general) nst = 0;
                default: if (hh || soft_rst) nst = 0;
                   else if (pd_general) nst = 2;
                   else if (m_e2) begin nst = 1; wk = 1; end
                   else if (!edpd_en) nst = 1;
            endcase
            if (nst == 0 && (m_st != 0 || hh)) m_cnt <= HOLD - 1;
            else if (m_st == 0 && m_cnt != 0) m_cnt <= m_cnt - 1;
            if (wk && irq_en) m_irq <= 1;
            else if (irq_clear) m_irq <= 0;
            if (!m_h2) m_low <= (m_low == MIN) ? MIN : m_low + 1;
            else m_low <= 0;
            m_st <= nst;
            m_e1 <= line_energy; m_e2 <= m_e1;
            m_h1 <= rst_pin_n;   m_h2 <= m_h1;
        end
    end

    function automatic logic [2:0] exp_core(input int st);
        case (st)
            0: return 3'b111;   // pwr, rst, inhibit
            1: return 3'b100;
            2: return 3'b011;
            default: return 3'b001;
        endcase
    endfunction

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    // Advance one cycle and compare every output with the model (R10 sequencing).
    task automatic tick(input string tag);
        @(negedge clk);
        if (core_rst) rst_seen = 1'b1;
        chk({core_pwr_en, core_rst, tx_inhibit} == exp_core(m_st), {tag, " R10 core"},
            {core_pwr_en, core_rst, tx_inhibit}, exp_core(m_st));
        chk(energy_on == m_e2, {tag, " R6 energy_on"}, energy_on, m_e2);
        chk(irq == m_irq, {tag, " R7 irq"}, irq, m_irq);
    endtask

    task automatic ticks(input int n, input string tag);
        for (int i = 0; i < n; i++) tick(tag);
    endtask

    int wd = 0;
    always @(posedge clk) begin
        wd++;
        if (wd > 150000) begin
            bad++; total++;
            $display("FAIL watchdog actual=%0d expected=%0d", wd, 150000);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        process::self().srandom(32'd4321);
        @(negedge clk);
        // R1: reset state while arst_n low
        chk({core_pwr_en, core_rst, tx_inhibit} == 3'b111, "R1 reset outputs",
            {core_pwr_en, core_rst, tx_inhibit}, 7);
        chk(irq == 0 && energy_on == 0, "R1 irq/energy at reset", {irq, energy_on}, 0);
        @(negedge clk);
        arst_n = 1'b1;
        ticks(HOLD - 1, "R1 hold");
        chk(core_rst == 1, "R1 still in reset", core_rst, 1);
        tick("R1 boot");
        chk({core_pwr_en, core_rst, tx_inhibit} == 3'b100, "R1 active after hold",
            {core_pwr_en, core_rst, tx_inhibit}, 4);

        // R6: two-edge latency
        line_energy = 1'b1;
        tick("R6");
        chk(energy_on == 0, "R6 after one edge", energy_on, 0);
        tick("R6");
        chk(energy_on == 1, "R6 after two edges", energy_on, 1);

        // R4: energy-detect sleep
        edpd_en = 1'b1;
        ticks(3, "R4 energy present");
        line_energy = 1'b0;
        ticks(3, "R4 sleep");
        chk({core_pwr_en, core_rst, tx_inhibit} == 3'b001, "R4 sleeping, R11 inhibit",
            {core_pwr_en, core_rst, tx_inhibit}, 1);

        // R5 / R7: wake with interrupt, no reset
        irq_en = 1'b1; rst_seen = 1'b0;
        line_energy = 1'b1;
        ticks(3, "R5 wake");
        chk(core_pwr_en == 1 && core_rst == 0, "R5 awake", {core_pwr_en, core_rst}, 2);
        chk(rst_seen == 0, "R5 no reset on wake", rst_seen, 0);
        chk(irq == 1, "R7 irq set on wake", irq, 1);
        ticks(4, "R7 sticky");
        chk(irq == 1, "R7 irq stays", irq, 1);
        irq_clear = 1'b1;
        tick("R7 clear");
        irq_clear = 1'b0;
        chk(irq == 0, "R7 irq cleared", irq, 0);

        // R4: no effect with edpd disabled
        edpd_en = 1'b0; line_energy = 1'b0;
        ticks(10, "R4 disabled");
        chk(core_pwr_en == 1, "R4 disabled stays powered", core_pwr_en, 1);

        // R2 / R3 / R9: general power-down, soft reset ignored there
        pd_general = 1'b1;
        tick("R2 enter");
        chk({core_pwr_en, core_rst, tx_inhibit} == 3'b011, "R2 powered down",
            {core_pwr_en, core_rst, tx_inhibit}, 3);
        soft_rst = 1'b1;
        tick("R9 ignored in pd");
        soft_rst = 1'b0;
        ticks(2, "R9 ignored in pd");
        chk(core_pwr_en == 0, "R9 soft ignored in PD_GENERAL", core_pwr_en, 0);
        pd_general = 1'b0;
        tick("R3 exit");
        chk(core_pwr_en == 1 && core_rst == 1, "R3 reset on exit", {core_pwr_en, core_rst}, 3);
        ticks(HOLD, "R3 hold");
        chk(core_rst == 0, "R3 active after hold", core_rst, 0);

        // R8: pulse one cycle short is ignored
        rst_seen = 1'b0;
        rst_pin_n = 1'b0;
        ticks(MIN - 1, "R8 short");
        rst_pin_n = 1'b1;
        ticks(6, "R8 short after");
        chk(rst_seen == 0, "R8 short pulse ignored", rst_seen, 0);
        // R8: pulse of exactly the minimum resets
        rst_pin_n = 1'b0;
        ticks(MIN, "R8 full");
        rst_pin_n = 1'b1;
        ticks(4, "R8 full after");
        chk(rst_seen == 1, "R8 qualified pulse resets", rst_seen, 1);
        ticks(HOLD + 2, "R8 recover");
        chk(core_rst == 0, "R8 recovered", core_rst, 0);

        // R9: soft reset in ACTIVE
        soft_rst = 1'b1;
        tick("R9 soft");
        soft_rst = 1'b0;
        chk(core_rst == 1 && core_pwr_en == 1, "R9 soft reset", {core_pwr_en, core_rst}, 3);
        ticks(HOLD, "R9 hold");

        // R10: soft reset beats power-down
        soft_rst = 1'b1; pd_general = 1'b1;
        tick("R10 prio");
        soft_rst = 1'b0;
        chk(core_pwr_en == 1 && core_rst == 1, "R10 soft over pd", {core_pwr_en, core_rst}, 3);
        pd_general = 1'b0;
        ticks(HOLD + 1, "R10 settle");

        // Random phase
        begin
            int hw_left = 0;
            for (int c = 0; c < 4000; c++) begin
                if ($urandom_range(7) == 0)   line_energy = ~line_energy;
                if ($urandom_range(199) == 0) pd_general  = ~pd_general;
                if ($urandom_range(99) == 0)  edpd_en     = ~edpd_en;
                if ($urandom_range(49) == 0)  irq_en      = ~irq_en;
                irq_clear = ($urandom_range(19) == 0);
                soft_rst  = ($urandom_range(149) == 0);
                if (hw_left == 0 && $urandom_range(299) == 0) hw_left = $urandom_range(40, 1);
                rst_pin_n = (hw_left == 0);
                if (hw_left > 0) hw_left--;
                tick("random");
            end
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule